// File: doc/BRIEF.md
# Two-Wire Trim Register Slave

This block is a two-wire serial bus slave that owns three 8-bit trim registers. It runs on a system clock that is much faster than the bus clock. Both bus lines are synchronised and deglitched inside the block. It then finds start, repeated start and stop conditions and the rising and falling edges of the bus clock. The slave address is a fixed four-bit device identifier plus select bits taken from strap pins. A parameter picks a one-strap variant in which only the lowest select bit comes from a pin.

A write carries a register pointer and then one data byte. That byte waits in a staging register. It is applied to the trim register only when a stop ends the transfer, and a single-cycle commit strobe then tells the external storage controller which pointer and value to save. The commit strobe is a plain pulse with no back-pressure. The storage controller pushes back through its busy input instead: while busy is high the slave acknowledges no byte, so a master can poll until the save has finished.

A read is a dummy write of the pointer, then a repeated start, then the address with the read bit set. The slave returns one register. Each trim register reaches the pins as a 7-bit position and a high-impedance flag. The bus data line is driven only through an active-high pull-down enable.

Top module: `trim_i2c_slave`

## Requirements
- R1: After reset the pull-down enable is low, every trim position is 0, every high-impedance flag is 0 and no commit strobe is issued.
- R2: The address byte is received MSB first as 1010, then three select bits, then a direction bit (1 = read, 0 = write). It is acknowledged only if the select bits equal strap_i[2:0]. In the one-strap variant the upper two select bits must be 0 and only strap_i[0] is compared.
- R3: After an address that does not match, the slave acknowledges nothing and leaves the data line released until the next start.
- R4: A write (address, pointer, data) gets an acknowledge (data line low during the ninth clock) on all three bytes. The trim register changes, and commit_o pulses for one cycle with commit_ptr_o and commit_data_o, only after the stop.
- R5: Pointers F8h, F9h and FAh select channels 0, 1 and 2. Bit 7 of a register appears on hiz_o[ch] and bits 6..0 on pos_o[7*ch +: 7].
- R6: A read after a pointer write and a repeated start returns the addressed register MSB first. During the master's ninth-bit NACK the slave keeps the line released.
- R7: A write to a pointer outside F8h..FAh is acknowledged but changes no register and issues no commit. A read from such a pointer returns 00h.
- R8: While busy_i is high, no byte is acknowledged and a write in progress is not committed.
- R9: A start seen at any point abandons the current transfer and restarts the bit count. A staged write abandoned by a repeated start is never committed, and a partial byte followed by a start does not disturb the next transfer.
- R10: A data byte after the first one in a write is not acknowledged. The first byte is still committed at the stop.
- R11: The pull-down enable changes only while the bus clock is low, except when it is released by a start or stop.
- R12: A bus clock pulse that lasts a single system clock cycle is filtered out and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Address select straps |
| busy_i | input | 1 | Storage controller busy; blocks all acknowledges |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| pos_o | output | 21 | Three 7-bit trim positions, channel 0 in the low bits |
| hiz_o | output | 3 | High-impedance flag per channel |
| commit_o | output | 1 | One-cycle strobe: a staged write was applied |
| commit_ptr_o | output | 8 | Pointer of the committed write |
| commit_data_o | output | 8 | Data of the committed write |

## Verification
The assertions assume that the master moves the data line only while the bus clock is low, except when it makes a start or stop on purpose. They also assume that every bus phase lasts well beyond the synchroniser and vote latency, so filtered edges follow the real ones in order. The stimulus holds each bus clock phase for twenty system cycles and changes data ten cycles into the low phase. Single-cycle clock glitches are added only inside low phases, where they must be filtered out. The busy input changes only between bytes, when the bus clock is low.

// File: rtl/trim_i2c_pkg.sv
package trim_i2c_pkg;
  localparam int          SEL_W  = 3;
  localparam int          POS_W  = 7;
  localparam logic [3:0]  DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_TXACK, S_IGNORE
  } slv_state_e;

  typedef enum logic [1:0] {
    B_ADDR, B_PTR, B_DATA, B_EXTRA
  } byte_sel_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW   = $clog2(VOTE_TAPS + 1);
  localparam int HALF = VOTE_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   tap_q;
  logic [CW-1:0]          ones;
  logic                   vote;
  logic                   line_q;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_TAPS; i++) ones = ones + CW'(tap_q[i]);
    vote = (ones > CW'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      tap_q  <= '1;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      tap_q  <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_q <= vote;
    end
  end

  assign line_o = line_q;

  // R12: a unanimous window decides the filtered level
  p_vote_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_q == '0) |=> !line_o);
  p_vote_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_q == '1) |=> line_o);
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/trim_i2c_engine.sv
module trim_i2c_engine
  import trim_i2c_pkg::*;
#(
  parameter bit SINGLE_STRAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             busy_i,
  input  logic [7:0]       rd_data_i,
  output logic [7:0]       ptr_o,
  output logic             sda_oe_o,
  output logic             wr_go_o,
  output logic [7:0]       wr_data_o
);
  slv_state_e       state_q;
  byte_sel_e        bsel_q;
  logic [2:0]       cnt_q;
  logic [7:0]       shreg_q, txsh_q, ptr_q, stage_q;
  logic             done_q, rw_q, armed_q, oe_q, go_q;
  logic [SEL_W-1:0] sel_exp;
  logic             addr_hit;

  generate
    if (SINGLE_STRAP) begin : g_one_strap
      assign sel_exp = {{(SEL_W-1){1'b0}}, strap_i[0]};
    end else begin : g_full_strap
      assign sel_exp = strap_i;
    end
  endgenerate

  assign addr_hit = (shreg_q[7:4] == DEV_ID) && (shreg_q[SEL_W:1] == sel_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      bsel_q  <= B_ADDR;
      cnt_q   <= '0;
      shreg_q <= '0;
      txsh_q  <= '0;
      ptr_q   <= '0;
      stage_q <= '0;
      done_q  <= 1'b0;
      rw_q    <= 1'b0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (start_i) begin
        state_q <= S_RX;
        bsel_q  <= B_ADDR;
        cnt_q   <= '0;
        done_q  <= 1'b0;
        oe_q    <= 1'b0;
        armed_q <= 1'b0;
      end else if (stop_i) begin
        go_q    <= armed_q;
        armed_q <= 1'b0;
        state_q <= S_IDLE;
        oe_q    <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        case (state_q)
          S_RX: begin
            if (scl_rise_i && !done_q) begin
              shreg_q <= {shreg_q[6:0], sda_i};
              cnt_q   <= cnt_q + 3'd1;
              if (cnt_q == 3'd7) done_q <= 1'b1;
            end else if (scl_fall_i && done_q) begin
              done_q <= 1'b0;
              cnt_q  <= '0;
              if (busy_i) begin
                state_q <= S_IGNORE;
              end else begin
                case (bsel_q)
                  B_ADDR: begin
                    if (addr_hit) begin
                      rw_q    <= shreg_q[0];
                      oe_q    <= 1'b1;
                      state_q <= S_ACK;
                    end else begin
                      state_q <= S_IGNORE;
                    end
                  end
                  B_PTR: begin
                    ptr_q   <= shreg_q;
                    oe_q    <= 1'b1;
                    state_q <= S_ACK;
                  end
                  B_DATA: begin
                    stage_q <= shreg_q;
                    armed_q <= 1'b1;
                    oe_q    <= 1'b1;
                    state_q <= S_ACK;
                  end
                  default: state_q <= S_IGNORE;
                endcase
              end
            end
          end
          S_ACK: begin
            if (scl_fall_i) begin
              if (bsel_q == B_ADDR && rw_q) begin
                state_q <= S_TX;
                txsh_q  <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
                cnt_q   <= '0;
              end else begin
                oe_q    <= 1'b0;
                state_q <= S_RX;
                case (bsel_q)
                  B_ADDR:  bsel_q <= B_PTR;
                  B_PTR:   bsel_q <= B_DATA;
                  default: bsel_q <= B_EXTRA;
                endcase
              end
            end
          end
          S_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == 3'd7) begin
                oe_q    <= 1'b0;
                state_q <= S_TXACK;
              end else begin
                cnt_q  <= cnt_q + 3'd1;
                txsh_q <= {txsh_q[6:0], 1'b0};
                oe_q   <= ~txsh_q[6];
              end
            end
          end
          S_TXACK: begin
            if (scl_rise_i) state_q <= S_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;
  assign wr_go_o   = go_q;
  assign wr_data_o = stage_q;

  // R8: a completed byte seen while busy leaves the line released
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RX && scl_fall_i && done_q && busy_i && !start_i && !stop_i) |=> !sda_oe_o);
  // R3: idle or ignoring means never pulling the line
  p_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE || state_q == S_IGNORE) |-> !sda_oe_o);
  // R11: the enable moves only with the bus clock low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> !$past(scl_i));
  // R4: staged data leaves only right after a stop
  p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go_o |-> $past(stop_i));
endmodule

// File: rtl/trim_reg_bank.sv
module trim_reg_bank
  import trim_i2c_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int REG_BASE = 'hF8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_go_i,
  input  logic [7:0]              ptr_i,
  input  logic [7:0]              wr_data_i,
  output logic [7:0]              rd_data_o,
  output logic [NUM_CH*POS_W-1:0] pos_o,
  output logic [NUM_CH-1:0]       hiz_o,
  output logic                    commit_o,
  output logic [7:0]              commit_ptr_o,
  output logic [7:0]              commit_data_o
);
  logic [7:0] reg_q [NUM_CH];
  logic       in_win;
  logic [7:0] off;
  logic       commit_q;
  logic [7:0] cptr_q, cdata_q;

  assign in_win = (int'(ptr_i) >= REG_BASE) && (int'(ptr_i) < REG_BASE + NUM_CH);
  assign off    = ptr_i - 8'(REG_BASE);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    reg_q[g] <= '0;
        else if (wr_go_i && in_win && off == 8'(g))    reg_q[g] <= wr_data_i;
      end
      assign pos_o[g*POS_W +: POS_W] = reg_q[g][POS_W-1:0];
      assign hiz_o[g]                = reg_q[g][7];
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (in_win && off == 8'(i)) rd_data_o = reg_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      cptr_q   <= '0;
      cdata_q  <= '0;
    end else begin
      commit_q <= wr_go_i && in_win;
      if (wr_go_i && in_win) begin
        cptr_q  <= ptr_i;
        cdata_q <= wr_data_i;
      end
    end
  end

  assign commit_o      = commit_q;
  assign commit_ptr_o  = cptr_q;
  assign commit_data_o = cdata_q;

  // R7: a commit only ever names a pointer inside the window
  p_commit_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (int'(commit_ptr_o) >= REG_BASE && int'(commit_ptr_o) < REG_BASE + NUM_CH));
  // R4: trim outputs change only together with a commit
  p_reg_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({hiz_o, pos_o}) |-> commit_o);
endmodule

// File: rtl/trim_i2c_slave.sv
module trim_i2c_slave
  import trim_i2c_pkg::*;
#(
  parameter bit SINGLE_STRAP = 1'b0,
  parameter int NUM_CH       = 3,
  parameter int REG_BASE     = 'hF8,
  parameter int SYNC_STAGES  = 2,
  parameter int VOTE_TAPS    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [SEL_W-1:0]        strap_i,
  input  logic                    busy_i,
  output logic                    sda_oe_o,
  output logic [NUM_CH*POS_W-1:0] pos_o,
  output logic [NUM_CH-1:0]       hiz_o,
  output logic                    commit_o,
  output logic [7:0]              commit_ptr_o,
  output logic [7:0]              commit_data_o
);
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, rd_data, wr_data;
  logic wr_go;

  i2c_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
  i2c_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

  i2c_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det));

  trim_i2c_engine #(.SINGLE_STRAP(SINGLE_STRAP)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .strap_i(strap_i), .busy_i(busy_i), .rd_data_i(rd_data),
    .ptr_o(ptr), .sda_oe_o(sda_oe_o), .wr_go_o(wr_go), .wr_data_o(wr_data));

  trim_reg_bank #(.NUM_CH(NUM_CH), .REG_BASE(REG_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_go_i(wr_go), .ptr_i(ptr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pos_o(pos_o), .hiz_o(hiz_o),
    .commit_o(commit_o), .commit_ptr_o(commit_ptr_o), .commit_data_o(commit_data_o));
endmodule

// File: tb/trim_i2c_slave_tb.sv
module trim_i2c_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic [20:0] pos;
  logic [2:0] hiz;
  logic commit;
  logic [7:0] cptr, cdata;
  wire sda_line = sda_m & ~sda_oe;

  int tests = 0, fails = 0, cycles = 0, commit_cnt = 0, oe_hi_moves = 0;
  logic glitch_en = 1'b0;
  logic [7:0] mdl [3];
  logic [7:0] last_cptr, last_cdata;

  always #5 clk = ~clk;

  trim_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .busy_i(busy), .sda_oe_o(sda_oe), .pos_o(pos), .hiz_o(hiz),
    .commit_o(commit), .commit_ptr_o(cptr), .commit_data_o(cdata));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (commit) begin
      commit_cnt <= commit_cnt + 1;
      last_cptr  <= cptr;
      last_cdata <= cdata;
    end
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    logic oe_a;
    sda_m = b;
    if (glitch_en) begin wt(4); scl_m = 1'b1; wt(1); scl_m = 1'b0; wt(5); end
    else wt(10);
    scl_m = 1'b1; wt(10);
    seen = sda_line; oe_a = sda_oe;
    wt(9);
    if (sda_oe !== oe_a) oe_hi_moves++;
    wt(1);
    scl_m = 1'b0; wt(10);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(10); scl_m = 1'b1; wt(10); sda_m = 1'b0; wt(10); scl_m = 1'b0; wt(10);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(10); scl_m = 1'b1; wt(10); sda_m = 1'b1; wt(30);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] v, output logic nack_line);
    logic s;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); v[i] = s; end
    bus_bit(1'b1, s);
    nack_line = s;
  endtask

  function automatic logic [7:0] reg_of(input int ch);
    return {hiz[ch], pos[ch*7 +: 7]};
  endfunction

  function automatic logic [7:0] mdl_rd(input logic [7:0] p);
    return (p >= 8'hF8 && p <= 8'hFA) ? mdl[p - 8'hF8] : 8'h00;
  endfunction

  task automatic chk_regs(input string tag);
    for (int c = 0; c < 3; c++) chk($sformatf("%s ch%0d", tag, c), reg_of(c), mdl[c]);
  endtask

  typedef struct packed {
    logic       rd;
    logic [7:0] dev;
    logic [7:0] ptr;
    logic [7:0] dat;
    logic       ack;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 8'hAA, 8'hF8, 8'h3F, 1'b1},
    '{1'b0, 8'hAA, 8'hF9, 8'h80, 1'b1},
    '{1'b0, 8'hAA, 8'hFA, 8'h7F, 1'b1},
    '{1'b1, 8'hAA, 8'hF9, 8'h00, 1'b1},
    '{1'b1, 8'hAA, 8'hFA, 8'h00, 1'b1},
    '{1'b0, 8'hAA, 8'hF5, 8'h55, 1'b1},
    '{1'b1, 8'hAA, 8'hF5, 8'h00, 1'b1},
    '{1'b0, 8'hA0, 8'hF8, 8'h11, 1'b0},
    '{1'b1, 8'hAA, 8'hF8, 8'h00, 1'b1},
    '{1'b0, 8'hAE, 8'hF8, 8'h22, 1'b0}
  };

  initial begin
    logic a0, a1, a2, a3, nl, s;
    logic [7:0] rv;
    int cc;
    for (int c = 0; c < 3; c++) mdl[c] = 8'h00;
    wt(5);
    // R1: reset state
    chk("R1 oe", {31'd0, sda_oe}, 0);
    chk_regs("R1 regs");
    rst_n = 1'b1;
    wt(20);
    chk("R1 no commit", commit_cnt, 0);
    chk("R1 oe after release", {31'd0, sda_oe}, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    foreach (VECS[k]) begin
      cc = commit_cnt;
      bus_start();
      send_byte(VECS[k].dev, a0);
      chk($sformatf("R2 addr ack v%0d", k), {31'd0, a0}, {31'd0, VECS[k].ack});
      send_byte(VECS[k].ptr, a1);
      if (!VECS[k].rd) begin
        send_byte(VECS[k].dat, a2);
        chk($sformatf("R4 ptr ack v%0d", k), {31'd0, a1}, {31'd0, VECS[k].ack});
        chk($sformatf("R4 data ack v%0d", k), {31'd0, a2}, {31'd0, VECS[k].ack});
        chk($sformatf("R4 staged until stop v%0d", k), commit_cnt, cc);
        bus_stop();
        if (VECS[k].ack && VECS[k].ptr >= 8'hF8 && VECS[k].ptr <= 8'hFA) begin
          mdl[VECS[k].ptr - 8'hF8] = VECS[k].dat;
          chk($sformatf("R4 commit v%0d", k), commit_cnt, cc + 1);
          chk($sformatf("R4 commit ptr v%0d", k), last_cptr, VECS[k].ptr);
          chk($sformatf("R4 commit data v%0d", k), last_cdata, VECS[k].dat);
        end else begin
          chk($sformatf("R7/R3 no commit v%0d", k), commit_cnt, cc);
        end
        chk_regs($sformatf("R5 regs v%0d", k));
      end else begin
        bus_start();
        send_byte(VECS[k].dev | 8'h01, a2);
        recv_byte(rv, nl);
        bus_stop();
        chk($sformatf("R6 ptr ack v%0d", k), {31'd0, a1}, 1);
        chk($sformatf("R6 read addr ack v%0d", k), {31'd0, a2}, 1);
        chk($sformatf("R6/R7 read data v%0d", k), rv, mdl_rd(VECS[k].ptr));
        chk($sformatf("R6 release at nack v%0d", k), {31'd0, nl}, 1);
      end
    end

    // R8: busy blocks every acknowledge
    cc = commit_cnt;
    busy = 1'b1;
    bus_start();
    send_byte(8'hAA, a0); send_byte(8'hF8, a1); send_byte(8'h55, a2);
    bus_stop();
    busy = 1'b0;
    chk("R8 addr nack", {31'd0, a0}, 0);
    chk("R8 data nack", {31'd0, a2}, 0);
    chk("R8 no commit", commit_cnt, cc);
    bus_start();
    send_byte(8'hAA, a0);
    busy = 1'b1;
    send_byte(8'hF9, a1); send_byte(8'h01, a2);
    busy = 1'b0;
    bus_stop();
    chk("R8 busy mid addr ack", {31'd0, a0}, 1);
    chk("R8 busy mid ptr nack", {31'd0, a1}, 0);
    chk("R8 busy mid no commit", commit_cnt, cc);
    chk_regs("R8 regs");

    // R9: repeated start abandons a staged write
    bus_start();
    send_byte(8'hAA, a0); send_byte(8'hF8, a1); send_byte(8'h44, a2);
    bus_start();
    bus_stop();
    chk("R9 acked before abort", {31'd0, a0 & a1 & a2}, 1);
    chk("R9 no commit after rstart", commit_cnt, cc);
    chk_regs("R9 regs kept");

    // R9: partial byte then start recovers
    bus_start();
    for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
    bus_start();
    send_byte(8'hAA, a0); send_byte(8'hF9, a1); send_byte(8'h12, a2);
    bus_stop();
    mdl[1] = 8'h12;
    chk("R9 recovery acks", {31'd0, a0 & a1 & a2}, 1);
    chk("R9 recovery commit", commit_cnt, cc + 1);
    chk_regs("R9 recovery regs");

    // R10: extra data byte refused, first byte kept
    bus_start();
    send_byte(8'hAA, a0); send_byte(8'hF8, a1); send_byte(8'h05, a2); send_byte(8'h06, a3);
    bus_stop();
    mdl[0] = 8'h05;
    chk("R10 first data ack", {31'd0, a2}, 1);
    chk("R10 extra nack", {31'd0, a3}, 0);
    chk("R10 commit data", last_cdata, 8'h05);
    chk_regs("R10 regs");

    // R12: one-cycle clock glitches inside low phases
    glitch_en = 1'b1;
    bus_start();
    send_byte(8'hAA, a0); send_byte(8'hFA, a1); send_byte(8'h2A, a2);
    glitch_en = 1'b0;
    bus_stop();
    mdl[2] = 8'h2A;
    chk("R12 acks with glitches", {31'd0, a0 & a1 & a2}, 1);
    chk_regs("R12 regs");

    // R11: enable never moved while the bus clock was high
    chk("R11 oe stable in high phase", oe_hi_moves, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule